// File: doc/BRIEF.md
# Memory Access Fault and Syndrome Unit

This unit sits beside the load/store path of a processor pipeline. Every access the pipeline presents is checked for natural alignment against its size and, when the access is marked as a stack access, against an inclusive address window held in two limit registers. The unit also receives bus-error indications from the instruction side and the data side.

When a fault is detected, the unit loads a fault-address register and a fault-status (syndrome) register and pulses an exception request for one cycle. The syndrome carries a 5-bit cause code and, for alignment faults, the access direction, the destination register number and a word-size flag. Misalignment is always recorded but only requests an exception when exceptions are enabled. Stack-window violations always request an exception. Bus errors are ignored while exceptions are disabled. When exceptions are enabled, a bus error records its address, and it sets the cause and requests an exception only if the matching configuration enable is set. The limit registers are loaded through a write port. The two syndrome registers are read directly from output ports. Translation, caching and exception vectoring belong to other blocks.

Top module: `access_fault_unit`

## Requirements
- R1: With `acc_size` encoded 0 = byte, 1 = halfword, 2 = word (3 behaves as word), a valid access is misaligned when the address ANDed with the size mask (0, 1, 3) is non-zero. Byte accesses never misalign.
- R2: A winning misalignment loads `fault_addr` with the access address. It loads `fault_status` with cause 1 in bits 4:0, `acc_dest` in bits 9:5, `acc_write` in bit 10 and a word-size flag in bit 11. All other bits are zero.
- R3: A winning misalignment records its syndrome whatever `exc_enable` is, and requests an exception only when `exc_enable` is 1.
- R4: A valid access with `acc_stack` = 1 whose address is below the low limit or above the high limit is a violation; an address equal to a limit is allowed. A winning violation records the address and cause 7 (all other status bits zero) and requests an exception regardless of `exc_enable`.
- R5: `lim_wr_en` with `lim_wr_sel` = 0 loads the low limit and with 1 loads the high limit. The new value governs checks from the following cycle. Reset sets low = 0 and high = all ones.
- R6: An instruction bus error is ignored while `exc_enable` is 0. Otherwise it records `ibus_addr`. With `cfg_ibus_exc` = 1 it also sets status to cause 3 and requests an exception. With `cfg_ibus_exc` = 0 it leaves the status unchanged and requests nothing.
- R7: A data bus error behaves as in R6, using `dbus_addr`, `cfg_dbus_exc` and cause 4.
- R8: When several faults occur in one cycle, only one is acted on, chosen in this order: instruction bus error (while enabled), misalignment, stack violation, data bus error (while enabled).
- R9: `exc_req` is high for exactly the one cycle after a cycle with a requesting fault. `fault_addr` and `fault_status` hold their values until the next fault that writes them.
- R10: Synchronous reset clears `fault_addr`, `fault_status` and `exc_req` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lim_wr_en | input | 1 | Limit register write strobe |
| lim_wr_sel | input | 1 | 0 selects low limit, 1 selects high limit |
| lim_wr_data | input | AW | Limit write value |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | AW | Access address |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_dest | input | 5 | Destination/source register number |
| acc_stack | input | 1 | Access is subject to the stack window check |
| exc_enable | input | 1 | Global exception enable |
| cfg_ibus_exc | input | 1 | Instruction bus error exceptions configured |
| cfg_dbus_exc | input | 1 | Data bus error exceptions configured |
| ibus_err | input | 1 | Instruction fetch bus error |
| ibus_addr | input | AW | Address of the failed instruction fetch |
| dbus_err | input | 1 | Data access bus error |
| dbus_addr | input | AW | Address of the failed data access |
| fault_addr | output | AW | Fault address register |
| fault_status | output | SW | Fault status (syndrome) register |
| exc_req | output | 1 | Exception request pulse |

## Verification
A wrong limit register shows up as a stack access near a boundary that faults or passes against the inclusive rule. This is visible on `exc_req` and `fault_status` one cycle after that access. A stale or wrongly selected syndrome shows up in `fault_addr` or `fault_status` at the first fault after the corruption, so the bench pairs every fault with an idle cycle that checks the hold behaviour. Priority mistakes appear in the same cycle that the competing faults resolve, which is why every combination of the four sources is driven together.

// File: rtl/afu_pkg.sv
package afu_pkg;
  localparam int CAUSE_W   = 5;
  localparam int DEST_W    = 5;
  localparam int DEST_LSB  = 5;
  localparam int WRITE_BIT = 10;
  localparam int WORD_BIT  = 11;
  localparam int NSRC      = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE      = 5'd0,
    CAUSE_UNALIGNED = 5'd1,
    CAUSE_IBUS      = 5'd3,
    CAUSE_DBUS      = 5'd4,
    CAUSE_STACK     = 5'd7
  } cause_e;

  // source slots, lower index wins
  localparam int SRC_IBUS  = 0;
  localparam int SRC_ALIGN = 1;
  localparam int SRC_STACK = 2;
  localparam int SRC_DBUS  = 3;
endpackage

// File: rtl/afu_align_check.sv
module afu_align_check #(
  parameter int AW = 32
) (
  input  logic          valid,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output logic          misaligned,
  output logic          is_word
);
  logic [1:0] size_mask;

  always_comb begin
    unique case (size)
      2'd0:    size_mask = 2'b00;
      2'd1:    size_mask = 2'b01;
      default: size_mask = 2'b11;
    endcase
  end

  assign is_word    = size[1];
  assign misaligned = valid && ((addr[1:0] & size_mask) != 2'b00);
endmodule

// File: rtl/afu_stack_window.sv
module afu_stack_window #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          chk_en,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] lim_lo,
  output logic [AW-1:0] lim_hi,
  output logic          violation
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lim_lo <= '0;
      lim_hi <= '1;
    end else if (wr_en) begin
      if (wr_sel) lim_hi <= wr_data;
      else        lim_lo <= wr_data;
    end
  end

  assign violation = chk_en && ((addr < lim_lo) || (addr > lim_hi));
endmodule

// File: rtl/afu_syndrome.sv
module afu_syndrome #(
  parameter int AW   = 32,
  parameter int SW   = 32,
  parameter int NSRC = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NSRC-1:0]          claim,
  input  logic [NSRC-1:0]          raise,
  input  logic [NSRC-1:0]          wr_stat,
  input  logic [NSRC-1:0][AW-1:0]  src_addr,
  input  logic [NSRC-1:0][SW-1:0]  src_stat,
  output logic [AW-1:0]            fault_addr,
  output logic [SW-1:0]            fault_status,
  output logic                     exc_req
);
  logic          hit;
  logic          sel_raise;
  logic          sel_wr;
  logic [AW-1:0] sel_addr;
  logic [SW-1:0] sel_stat;

  // walk from lowest priority upward so the lowest index is kept last
  always_comb begin
    hit       = 1'b0;
    sel_raise = 1'b0;
    sel_wr    = 1'b0;
    sel_addr  = '0;
    sel_stat  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (claim[i]) begin
        hit       = 1'b1;
        sel_raise = raise[i];
        sel_wr    = wr_stat[i];
        sel_addr  = src_addr[i];
        sel_stat  = src_stat[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_addr   <= '0;
      fault_status <= '0;
      exc_req      <= 1'b0;
    end else begin
      exc_req <= hit && sel_raise;
      if (hit) fault_addr <= sel_addr;
      if (hit && sel_wr) fault_status <= sel_stat;
    end
  end
endmodule

// File: rtl/access_fault_unit.sv
module access_fault_unit
  import afu_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lim_wr_en,
  input  logic          lim_wr_sel,
  input  logic [AW-1:0] lim_wr_data,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic          acc_write,
  input  logic [4:0]    acc_dest,
  input  logic          acc_stack,
  input  logic          exc_enable,
  input  logic          cfg_ibus_exc,
  input  logic          cfg_dbus_exc,
  input  logic          ibus_err,
  input  logic [AW-1:0] ibus_addr,
  input  logic          dbus_err,
  input  logic [AW-1:0] dbus_addr,
  output logic [AW-1:0] fault_addr,
  output logic [SW-1:0] fault_status,
  output logic          exc_req
);
  logic          misaligned;
  logic          is_word;
  logic          stk_viol;
  logic [AW-1:0] lim_lo;
  logic [AW-1:0] lim_hi;

  logic [NSRC-1:0]         claim;
  logic [NSRC-1:0]         raise;
  logic [NSRC-1:0]         wr_stat;
  logic [NSRC-1:0][AW-1:0] src_addr;
  logic [NSRC-1:0][SW-1:0] src_stat;

  afu_align_check #(.AW(AW)) align_i (
    .valid      (acc_valid),
    .addr       (acc_addr),
    .size       (acc_size),
    .misaligned (misaligned),
    .is_word    (is_word)
  );

  afu_stack_window #(.AW(AW)) window_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (lim_wr_en),
    .wr_sel    (lim_wr_sel),
    .wr_data   (lim_wr_data),
    .chk_en    (acc_valid && acc_stack),
    .addr      (acc_addr),
    .lim_lo    (lim_lo),
    .lim_hi    (lim_hi),
    .violation (stk_viol)
  );

  always_comb begin
    claim    = '0;
    raise    = '0;
    wr_stat  = '0;
    src_addr = '0;
    src_stat = '0;

    claim[SRC_IBUS]    = ibus_err && exc_enable;
    raise[SRC_IBUS]    = cfg_ibus_exc;
    wr_stat[SRC_IBUS]  = cfg_ibus_exc;
    src_addr[SRC_IBUS] = ibus_addr;
    src_stat[SRC_IBUS][CAUSE_W-1:0] = CAUSE_IBUS;

    claim[SRC_ALIGN]    = misaligned;
    raise[SRC_ALIGN]    = exc_enable;
    wr_stat[SRC_ALIGN]  = 1'b1;
    src_addr[SRC_ALIGN] = acc_addr;
    src_stat[SRC_ALIGN][CAUSE_W-1:0]                 = CAUSE_UNALIGNED;
    src_stat[SRC_ALIGN][DEST_LSB +: DEST_W]          = acc_dest;
    src_stat[SRC_ALIGN][WRITE_BIT]                   = acc_write;
    src_stat[SRC_ALIGN][WORD_BIT]                    = is_word;

    claim[SRC_STACK]    = stk_viol;
    raise[SRC_STACK]    = 1'b1;
    wr_stat[SRC_STACK]  = 1'b1;
    src_addr[SRC_STACK] = acc_addr;
    src_stat[SRC_STACK][CAUSE_W-1:0] = CAUSE_STACK;

    claim[SRC_DBUS]    = dbus_err && exc_enable;
    raise[SRC_DBUS]    = cfg_dbus_exc;
    wr_stat[SRC_DBUS]  = cfg_dbus_exc;
    src_addr[SRC_DBUS] = dbus_addr;
    src_stat[SRC_DBUS][CAUSE_W-1:0] = CAUSE_DBUS;
  end

  afu_syndrome #(.AW(AW), .SW(SW), .NSRC(NSRC)) synd_i (
    .clk          (clk),
    .rst          (rst),
    .claim        (claim),
    .raise        (raise),
    .wr_stat      (wr_stat),
    .src_addr     (src_addr),
    .src_stat     (src_stat),
    .fault_addr   (fault_addr),
    .fault_status (fault_status),
    .exc_req      (exc_req)
  );
endmodule

// File: rtl/afu_checker.sv
module afu_checker #(
  parameter int AW = 32,
  parameter int SW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic [1:0]    acc_size,
  input logic          acc_stack,
  input logic          exc_enable,
  input logic          cfg_ibus_exc,
  input logic          ibus_err,
  input logic          dbus_err,
  input logic [AW-1:0] lim_lo,
  input logic [AW-1:0] lim_hi,
  input logic [AW-1:0] fault_addr,
  input logic [SW-1:0] fault_status,
  input logic          exc_req
);
  logic mis_c, out_c, ib_c, db_c, any_c;

  assign mis_c = acc_valid &&
                 ((acc_size == 2'd1 && acc_addr[0]) ||
                  (acc_size[1] && (acc_addr[0] || acc_addr[1])));
  assign out_c = acc_valid && acc_stack &&
                 !((acc_addr >= lim_lo) && (acc_addr <= lim_hi));
  assign ib_c  = ibus_err && exc_enable;
  assign db_c  = dbus_err && exc_enable;
  assign any_c = ib_c || mis_c || out_c || db_c;

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!exc_req && fault_status == '0 && fault_addr == '0));

  assert_align_syndrome_R2: assert property (@(posedge clk) disable iff (rst)
    (!ib_c && mis_c) |=> (fault_status[4:0] == 5'd1 && fault_addr == $past(acc_addr)));

  assert_align_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!ib_c && mis_c && !exc_enable) |=> !exc_req);

  assert_stack_raise_R4: assert property (@(posedge clk) disable iff (rst)
    (!ib_c && !mis_c && out_c) |=> (exc_req && fault_status[4:0] == 5'd7));

  assert_ibus_cause_R6: assert property (@(posedge clk) disable iff (rst)
    (ib_c && cfg_ibus_exc) |=> (exc_req && fault_status[4:0] == 5'd3));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!any_c && !$past(rst)) |=> (!exc_req && $stable(fault_addr) && $stable(fault_status)));
endmodule

bind access_fault_unit afu_checker #(.AW(AW), .SW(SW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .acc_valid    (acc_valid),
  .acc_addr     (acc_addr),
  .acc_size     (acc_size),
  .acc_stack    (acc_stack),
  .exc_enable   (exc_enable),
  .cfg_ibus_exc (cfg_ibus_exc),
  .ibus_err     (ibus_err),
  .dbus_err     (dbus_err),
  .lim_lo       (lim_lo),
  .lim_hi       (lim_hi),
  .fault_addr   (fault_addr),
  .fault_status (fault_status),
  .exc_req      (exc_req)
);

// File: tb/access_fault_unit_tb_top.sv
`timescale 1ns/1ps
module access_fault_unit_tb_top;
  localparam int AW = 32;
  localparam int SW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lim_wr_en = 0, lim_wr_sel = 0;
  logic [AW-1:0] lim_wr_data = '0;
  logic          acc_valid = 0, acc_write = 0, acc_stack = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0]    acc_size = '0;
  logic [4:0]    acc_dest = '0;
  logic          exc_enable = 0, cfg_ibus_exc = 0, cfg_dbus_exc = 0;
  logic          ibus_err = 0, dbus_err = 0;
  logic [AW-1:0] ibus_addr = '0, dbus_addr = '0;
  logic [AW-1:0] fault_addr;
  logic [SW-1:0] fault_status;
  logic          exc_req;

  int errors = 0;
  int checks = 0;
  logic [AW-1:0] m_lo = '0, m_hi = '1, m_addr = '0;
  logic [SW-1:0] m_stat = '0;
  logic          m_req = 1'b0;

  always #10 clk = ~clk;

  access_fault_unit #(.AW(AW), .SW(SW)) dut_i (
    .clk(clk), .rst(rst),
    .lim_wr_en(lim_wr_en), .lim_wr_sel(lim_wr_sel), .lim_wr_data(lim_wr_data),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_write(acc_write), .acc_dest(acc_dest), .acc_stack(acc_stack),
    .exc_enable(exc_enable), .cfg_ibus_exc(cfg_ibus_exc), .cfg_dbus_exc(cfg_dbus_exc),
    .ibus_err(ibus_err), .ibus_addr(ibus_addr), .dbus_err(dbus_err), .dbus_addr(dbus_addr),
    .fault_addr(fault_addr), .fault_status(fault_status), .exc_req(exc_req)
  );

  task automatic clear_inputs();
    lim_wr_en = 0; acc_valid = 0; acc_stack = 0; acc_write = 0;
    acc_size = 0; acc_addr = '0; acc_dest = '0;
    ibus_err = 0; dbus_err = 0;
  endtask

  // expected next state from the requirement rules
  task automatic model();
    logic [1:0] mask;
    logic mis, outw, ic, dc;
    mask = (acc_size == 2'd0) ? 2'd0 : (acc_size == 2'd1) ? 2'd1 : 2'd3;
    mis  = acc_valid && ((acc_addr[1:0] & mask) != 0);
    outw = acc_valid && acc_stack && (acc_addr < m_lo || acc_addr > m_hi);
    ic   = ibus_err && exc_enable;
    dc   = dbus_err && exc_enable;
    m_req = 1'b0;
    if (ic) begin
      m_addr = ibus_addr;
      if (cfg_ibus_exc) begin m_stat = SW'(3); m_req = 1'b1; end
    end else if (mis) begin
      m_addr = acc_addr;
      m_stat = SW'(1) | (SW'(acc_dest) << 5) | (SW'(acc_write) << 10) |
               (SW'(acc_size >= 2) << 11);
      m_req  = exc_enable;
    end else if (outw) begin
      m_addr = acc_addr; m_stat = SW'(7); m_req = 1'b1;
    end else if (dc) begin
      m_addr = dbus_addr;
      if (cfg_dbus_exc) begin m_stat = SW'(4); m_req = 1'b1; end
    end
    if (lim_wr_en) begin
      if (lim_wr_sel) m_hi = lim_wr_data; else m_lo = lim_wr_data;
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (fault_addr !== m_addr || fault_status !== m_stat || exc_req !== m_req) begin
      errors++;
      $display("FAIL %s: addr=%h status=%h req=%b expected addr=%h status=%h req=%b",
               tag, fault_addr, fault_status, exc_req, m_addr, m_stat, m_req);
    end
  endtask

  // inputs already set during the low phase; check after the edge
  task automatic step(string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    clear_inputs();
  endtask

  task automatic idle(string tag);
    step(tag);
  endtask

  task automatic set_limit(bit hi, logic [AW-1:0] v);
    lim_wr_en = 1; lim_wr_sel = hi; lim_wr_data = v;
    step("R5");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    compare("R10");  // reset state

    // R5: reset limits leave the whole space inside the window
    acc_valid = 1; acc_stack = 1; acc_size = 2; acc_addr = '0;          step("R5");
    acc_valid = 1; acc_stack = 1; acc_size = 2; acc_addr = 32'hFFFF_FFFC; step("R5");

    // R1 R2 R3 R9: alignment sweep over low bits, sizes, direction, enable
    for (int en = 0; en < 2; en++)
      for (int sz = 0; sz < 4; sz++)
        for (int lo = 0; lo < 4; lo++)
          for (int wr = 0; wr < 2; wr++) begin
            exc_enable = en[0];
            acc_valid = 1; acc_size = sz[1:0]; acc_write = wr[0];
            acc_addr = 32'h4000_0100 + lo;
            acc_dest = 5'((lo * 7 + sz * 3 + wr * 11 + en) & 31);
            step((sz == 0) ? "R1" : (en == 0 ? "R3" : "R2"));
            idle("R9");
          end
    // misaligned but not valid: no effect
    exc_enable = 1; acc_valid = 0; acc_size = 2; acc_addr = 32'h3; step("R1");

    // R5 R4: program window 0x100..0x1FF and probe around the limits
    set_limit(0, 32'h100);
    set_limit(1, 32'h1FF);
    for (int en = 0; en < 2; en++) begin
      exc_enable = en[0];
      acc_valid = 1; acc_stack = 1; acc_size = 2; acc_addr = 32'hFC;  step("R4"); idle("R9");
      acc_valid = 1; acc_stack = 1; acc_size = 2; acc_addr = 32'h100; step("R4");
      acc_valid = 1; acc_stack = 1; acc_size = 0; acc_addr = 32'h1FF; step("R4");
      acc_valid = 1; acc_stack = 1; acc_size = 0; acc_addr = 32'h200; step("R4"); idle("R9");
      acc_valid = 1; acc_stack = 0; acc_size = 2; acc_addr = 32'h400; step("R4");
    end
    // R5: a limit written this cycle does not govern this cycle's access
    lim_wr_en = 1; lim_wr_sel = 0; lim_wr_data = 32'h180;
    acc_valid = 1; acc_stack = 1; acc_size = 2; acc_addr = 32'h140; step("R5");
    acc_valid = 1; acc_stack = 1; acc_size = 2; acc_addr = 32'h140; step("R5");
    acc_valid = 1; acc_stack = 1; acc_size = 2; acc_addr = 32'h180; step("R5");
    set_limit(0, 32'h100);

    // R6 R7: bus errors across enable and configuration
    for (int en = 0; en < 2; en++)
      for (int cf = 0; cf < 2; cf++) begin
        exc_enable = en[0]; cfg_ibus_exc = cf[0]; cfg_dbus_exc = cf[0];
        ibus_err = 1; ibus_addr = 32'hA000_0000 + en * 16 + cf; step("R6"); idle("R9");
        dbus_err = 1; dbus_addr = 32'hD000_0000 + en * 16 + cf; step("R7"); idle("R9");
      end
    cfg_ibus_exc = 0; cfg_dbus_exc = 1; exc_enable = 1;
    dbus_err = 1; dbus_addr = 32'hD000_0100; step("R7");
    ibus_err = 1; ibus_addr = 32'hA000_0100; step("R6");

    // R8: every combination of the four sources in one cycle
    for (int cf = 0; cf < 2; cf++)
      for (int m = 0; m < 16; m++) begin
        exc_enable = 1; cfg_ibus_exc = cf[0]; cfg_dbus_exc = 1;
        ibus_err = m[0]; ibus_addr = 32'hA100_0000 + m;
        acc_valid = 1; acc_stack = 1; acc_size = 2; acc_write = m[3];
        acc_dest = 5'(m + 3);
        acc_addr = (m[2] ? 32'h300 : 32'h180) | (m[1] ? 32'h1 : 32'h0);
        dbus_err = m[3]; dbus_addr = 32'hD100_0000 + m;
        step("R8");
        idle("R9");
      end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule